// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of an open-drain two-wire serial bus, placed in front of a byte-wide memory array built from registers. The array size is a parameter from 128 to 2048 bytes, and it must be a power of two. Both bus lines are oversampled on the system clock. From the samples the block detects start and stop conditions and shifts bytes in MSB first. It drives acknowledges and read data through a single pull-low enable. The bus itself and its pull-up are outside the block.

A command byte holds a 7-bit device identifier followed by a direction bit. Writes go through these states: `ST_CMD` to `ST_CMD_ACK`, then `ST_ADDR` and `ST_ADDR_ACK` once for each address byte, then `ST_WDATA` and `ST_WDATA_ACK` for each data byte. Data bytes are collected in a page buffer and are written to the array only when a stop arrives. A busy interval follows each commit. Reads leave `ST_CMD_ACK` for `ST_RDATA` and alternate between `ST_RDATA` and `ST_RDATA_ACK` for as long as the host acknowledges. A random read is formed by a write header that carries only an address, followed by a repeated start. Without that header, a read continues from the current address pointer. A stop sends every state to `ST_IDLE`. A start sends every state to `ST_CMD`. A refused command, or a read the host does not acknowledge, leaves `ST_CMD_ACK` or `ST_RDATA_ACK` for `ST_IDLE`.

Top module: `tws_eeprom`

## Requirements
- R1: After reset, `sda_oe` is 0, the block waits in `ST_IDLE` for a start, and every array byte reads as 0x00.
- R2: SDA falling while SCL is high is a start. SDA rising while SCL is high is a stop. A change on SDA while SCL is high is never taken as a data bit, so a repeated start between the address header and a read command is accepted.
- R3: Data bits are sampled on SCL rising edges, MSB first. The block changes `sda_oe` only while SCL is low, after a falling edge.
- R4: The command byte is {DEV_ID[6:0], dir}, where dir = 1 means read and dir = 0 means write. The block pulls SDA low on the ninth clock only if the identifier matches and no commit is busy. Otherwise it releases SDA and ignores the bus until the next start.
- R5: After a write command come ceil(log2(MEM_BYTES)/8) address bytes, MSB first. Their low log2(MEM_BYTES) bits load the address pointer, and each address byte is acknowledged.
- R6: Each write data byte is acknowledged and held in a page buffer. Only a stop copies the held bytes into the array, and a page may be written partly.
- R7: The page is 8 bytes when MEM_BYTES <= 256 and 16 bytes otherwise. Within a write, the pointer's low page bits wrap inside the page, so a later byte overwrites an earlier one at the same position.
- R8: A commit starts a busy interval of BUSY_CYCLES clocks. During that interval every command is refused as in R4.
- R9: In a read, each byte sent advances the pointer, wrapping from MEM_BYTES-1 to 0. A host acknowledge on the ninth clock requests the next byte.
- R10: A missing host acknowledge ends the read. The block releases SDA and drives nothing more until a start.
- R11: A start in the middle of any transfer discards the buffered write bytes without a commit and restarts command reception.
- R12: A read command with no address header reads from the pointer left by the last access: one past the last byte read, or the address most recently loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock level seen on the bus |
| sda_in | input | 1 | Serial data level seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench first fills every page of a 256-byte array and then reads the whole array back in one stream that runs one byte past the top. A pointer that does not wrap, or a commit to the wrong page, shows up there as wrong bytes. A 10-byte write that starts two bytes before a page end checks in-page wrapping: a design that carries into the next page corrupts address 0x20, and one that keeps the first bytes leaves stale data at 0x1E. Further sequences check the refusal of a command during the busy time, the absence of a commit for an address-only header, a third byte cut off by a repeated start, a wrong identifier, the pointer state after a current-address read, and SDA staying released after a host's missing acknowledge. Each of these catches a design that commits too early, keeps stale buffer bytes, or keeps driving the bus.

// File: rtl/tws_pkg.sv
package tws_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_CMD_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } tws_state_e;

endpackage

// File: rtl/tws_line_sync.sv
// Oversamples both bus lines and derives clock edges and start/stop events.
module tws_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // Idle bus is high, so the pipeline resets to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_lvl  = scl_pipe[STAGES-1];
    assign sda_lvl  = sda_pipe[STAGES-1];
    assign scl_rise = scl_lvl & ~scl_q;
    assign scl_fall = ~scl_lvl & scl_q;
    assign start_ev = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_ev  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/tws_busy_timer.sv
// Models the self-timed commit interval.
module tws_busy_timer #(
    parameter int BUSY_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= CW'(BUSY_CYCLES);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign busy = (left_q != '0);

endmodule

// File: rtl/tws_page_store.sv
// Register array plus the page buffer that holds write bytes until a commit.
module tws_page_store #(
    parameter int MEM_BYTES  = 256,
    parameter int PAGE_BYTES = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         wr_en,
    input  logic [$clog2(MEM_BYTES)-1:0] wr_addr,
    input  logic [7:0]                   wr_data,
    input  logic                         commit_req,
    output logic                         commit,
    output logic                         pending,
    input  logic [$clog2(MEM_BYTES)-1:0] rd_addr,
    output logic [7:0]                   rd_data
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);

    logic [7:0]     mem_q   [MEM_BYTES];
    logic [7:0]     slot_q  [PAGE_BYTES];
    logic           held_q  [PAGE_BYTES];
    logic [AW-PW-1:0] page_q;

    always_comb begin
        pending = 1'b0;
        for (int i = 0; i < PAGE_BYTES; i++) begin
            pending = pending | held_q[i];
        end
    end

    assign commit = commit_req & pending;

    genvar g;
    generate
        for (g = 0; g < PAGE_BYTES; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    slot_q[g] <= '0;
                    held_q[g] <= 1'b0;
                end else if (clr || commit) begin
                    held_q[g] <= 1'b0;
                end else if (wr_en && (wr_addr[PW-1:0] == PW'(g))) begin
                    slot_q[g] <= wr_data;
                    held_q[g] <= 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (wr_en) begin
            page_q <= wr_addr[AW-1:PW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) begin
                mem_q[i] <= '0;
            end
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (held_q[i]) begin
                    mem_q[{page_q, PW'(i)}] <= slot_q[i];
                end
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/tws_eeprom.sv
module tws_eeprom #(
    parameter int         MEM_BYTES   = 256,
    parameter int         BUSY_CYCLES = 50000,
    parameter logic [6:0] DEV_ID      = 7'h50,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);
    import tws_pkg::*;

    localparam int AW         = $clog2(MEM_BYTES);
    localparam int PAGE_BYTES = (MEM_BYTES <= 256) ? 8 : 16;
    localparam int PW         = $clog2(PAGE_BYTES);
    localparam int ABYTES     = (AW + 7) / 8;
    localparam int ACCW       = ABYTES * 8;
    localparam int ABW        = $clog2(ABYTES + 1);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic busy, commit, pending;
    logic [7:0] rd_data;

    tws_state_e state_q, state_d;
    logic [2:0]      cnt_q;
    logic [6:0]      sh_q;
    logic            ack_ok_q;
    logic            rw_q;
    logic            seen_q;
    logic            host_ack_q;
    logic [ACCW-1:0] acc_q;
    logic [ABW-1:0]  abyte_q;
    logic [AW-1:0]   ptr_q;
    logic [7:0]      rd_sh_q;
    logic            oe_q;

    logic [7:0]      rx_byte;
    logic [ACCW-1:0] acc_next;
    logic            in_byte, in_ack, byte_done, ack_exit, last_addr, load_rd, buf_we;

    tws_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    tws_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (commit),
        .busy  (busy)
    );

    tws_page_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (start_ev),
        .wr_en      (buf_we),
        .wr_addr    (ptr_q),
        .wr_data    (rx_byte),
        .commit_req (stop_ev),
        .commit     (commit),
        .pending    (pending),
        .rd_addr    (ptr_q),
        .rd_data    (rd_data)
    );

    // Decode helpers
    assign rx_byte   = {sh_q, sda_lvl};
    assign acc_next  = (acc_q << 8) | ACCW'(rx_byte);
    assign in_byte   = (state_q == ST_CMD) || (state_q == ST_ADDR) ||
                       (state_q == ST_WDATA) || (state_q == ST_RDATA);
    assign in_ack    = (state_q == ST_CMD_ACK) || (state_q == ST_ADDR_ACK) ||
                       (state_q == ST_WDATA_ACK) || (state_q == ST_RDATA_ACK);
    assign byte_done = scl_rise && (cnt_q == 3'd7) && in_byte;
    assign ack_exit  = scl_fall && seen_q && in_ack;
    assign last_addr = (abyte_q == ABW'(ABYTES));
    assign load_rd   = ack_exit &&
                       (((state_q == ST_CMD_ACK) && ack_ok_q && rw_q) ||
                        ((state_q == ST_RDATA_ACK) && host_ack_q));
    assign buf_we    = (state_q == ST_WDATA) && byte_done;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_ev) begin
            state_d = ST_IDLE;
        end else if (start_ev) begin
            state_d = ST_CMD;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_CMD:       if (byte_done) state_d = ST_CMD_ACK;
                ST_CMD_ACK:   if (ack_exit)
                                  state_d = !ack_ok_q ? ST_IDLE : (rw_q ? ST_RDATA : ST_ADDR);
                ST_ADDR:      if (byte_done) state_d = ST_ADDR_ACK;
                ST_ADDR_ACK:  if (ack_exit) state_d = last_addr ? ST_WDATA : ST_ADDR;
                ST_WDATA:     if (byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (ack_exit) state_d = ST_WDATA;
                ST_RDATA:     if (byte_done) state_d = ST_RDATA_ACK;
                ST_RDATA_ACK: if (ack_exit) state_d = host_ack_q ? ST_RDATA : ST_IDLE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // Datapath and output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            sh_q       <= '0;
            ack_ok_q   <= 1'b0;
            rw_q       <= 1'b0;
            seen_q     <= 1'b0;
            host_ack_q <= 1'b0;
            acc_q      <= '0;
            abyte_q    <= '0;
            ptr_q      <= '0;
            rd_sh_q    <= '0;
            oe_q       <= 1'b0;
        end else if (start_ev || stop_ev) begin
            cnt_q   <= '0;
            seen_q  <= 1'b0;
            abyte_q <= '0;
            oe_q    <= 1'b0;
        end else begin
            if (scl_rise && in_byte) begin
                cnt_q <= cnt_q + 1'b1;
                sh_q  <= {sh_q[5:0], sda_lvl};
            end
            if (byte_done) begin
                seen_q <= 1'b0;
            end
            case (state_q)
                ST_CMD: begin
                    if (byte_done) begin
                        ack_ok_q <= (rx_byte[7:1] == DEV_ID) && !busy;
                        rw_q     <= rx_byte[0];
                    end
                end
                ST_ADDR: begin
                    if (byte_done) begin
                        acc_q   <= acc_next;
                        abyte_q <= abyte_q + 1'b1;
                        ptr_q   <= acc_next[AW-1:0];
                    end
                end
                ST_WDATA: begin
                    if (byte_done) begin
                        ptr_q <= {ptr_q[AW-1:PW], ptr_q[PW-1:0] + 1'b1};
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        rd_sh_q <= {rd_sh_q[6:0], 1'b0};
                        oe_q    <= ~rd_sh_q[6];
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) begin
                        seen_q     <= 1'b1;
                        host_ack_q <= ~sda_lvl;
                    end
                    if (scl_fall) begin
                        oe_q <= 1'b0;
                    end
                end
                ST_CMD_ACK, ST_ADDR_ACK, ST_WDATA_ACK: begin
                    if (scl_rise) begin
                        seen_q <= 1'b1;
                    end
                    if (scl_fall) begin
                        if (!seen_q) begin
                            oe_q <= (state_q == ST_CMD_ACK) ? ack_ok_q : 1'b1;
                        end else begin
                            oe_q <= 1'b0;
                        end
                    end
                end
                default: begin
                end
            endcase
            if (load_rd) begin
                rd_sh_q <= rd_data;
                oe_q    <= ~rd_data[7];
                ptr_q   <= ptr_q + 1'b1;
            end
        end
    end

    assign sda_oe = oe_q;

endmodule

// File: rtl/tws_eeprom_chk.sv
module tws_eeprom_chk (
    input logic                clk,
    input logic                rst_n,
    input logic                scl_lvl,
    input logic                sda_oe,
    input tws_pkg::tws_state_e state,
    input logic                busy,
    input logic                commit,
    input logic                pending,
    input logic                start_ev,
    input logic                stop_ev
);
    import tws_pkg::*;

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl); // R3

    AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state == ST_CMD_ACK) |-> !sda_oe); // R8

    AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(commit)); // R8

    AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> stop_ev); // R6

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe); // R10

    AST_START_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_CMD && !pending)); // R11

endmodule

bind tws_eeprom tws_eeprom_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_lvl),
    .sda_oe   (sda_oe),
    .state    (state_q),
    .busy     (busy),
    .commit   (commit),
    .pending  (pending),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
);

// File: tb/sim_tws_eeprom.sv
`timescale 1ns/1ps
module sim_tws_eeprom;
    localparam int         MEM   = 256;
    localparam int         BUSY  = 400;
    localparam logic [6:0] ID    = 7'h50;
    localparam int         H     = 8;
    localparam int         PAGE  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic host_low = 1'b0;
    logic sda_oe;
    logic sda_bus;
    int   tests = 0;
    int   fails = 0;
    bit   done = 1'b0;
    logic [7:0] model [MEM];

    always #5 clk = ~clk;

    assign sda_bus = ~(host_low | sda_oe);

    tws_eeprom #(.MEM_BYTES(MEM), .BUSY_CYCLES(BUSY), .DEV_ID(ID), .SYNC_STAGES(2)) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl),
        .sda_in (sda_bus),
        .sda_oe (sda_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wbit(input logic b);
        host_low = ~b;
        tick(H); scl = 1'b1;
        tick(H); scl = 1'b0;
    endtask

    task automatic rbit(output logic b);
        host_low = 1'b0;
        tick(H); scl = 1'b1;
        tick(H/2); b = sda_bus;
        tick(H - H/2); scl = 1'b0;
    endtask

    task automatic bus_start();
        host_low = 1'b0;
        tick(H); scl = 1'b1;
        tick(H); host_low = 1'b1;
        tick(H); scl = 1'b0;
    endtask

    task automatic bus_stop();
        host_low = 1'b1;
        tick(H); scl = 1'b1;
        tick(H); host_low = 1'b0;
        tick(H);
    endtask

    task automatic send_byte(input logic [7:0] v, output int ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(b);
        ack = (b == 1'b0) ? 1 : 0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            v[i] = b;
        end
        wbit(~give_ack);
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'((seed + k * 29) & 255);
    endfunction

    // Full write: header, n data bytes, stop. Model follows in-page wrapping.
    task automatic do_write(input int addr, input int n, input int seed);
        int a;
        bus_start();
        send_byte({ID, 1'b0}, a); chk("R4 write command ack", a, 1);
        send_byte(8'(addr), a);   chk("R5 address byte ack", a, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(pat(seed, k), a);
            chk("R6 data byte ack", a, 1);
            model[(addr & ~(PAGE - 1)) | ((addr + k) & (PAGE - 1))] = pat(seed, k);
        end
        bus_stop();
    endtask

    // Random read of n bytes through a repeated start
    task automatic do_read(input int addr, input int n, input string tag);
        int a;
        logic [7:0] v;
        bus_start();
        send_byte({ID, 1'b0}, a); chk("R4 header command ack", a, 1);
        send_byte(8'(addr), a);   chk("R5 read address ack", a, 1);
        bus_start();
        send_byte({ID, 1'b1}, a); chk("R2 repeated start read command ack", a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, v);
            chk(tag, int'(v), int'(model[(addr + k) % MEM]));
        end
        bus_stop();
    endtask

    initial begin
        int a;
        logic b;
        logic [7:0] v;
        for (int i = 0; i < MEM; i++) model[i] = 8'h00;
        tick(10);
        chk("R1 sda_oe released in reset", int'(sda_oe), 0);
        rst_n = 1'b1;
        tick(10);
        chk("R1 sda_oe released after reset", int'(sda_oe), 0);
        do_read(8'h05, 1, "R1 array cleared by reset");

        // Sweep: every page written in full
        for (int p = 0; p < MEM / PAGE; p++) begin
            do_write(p * PAGE, PAGE, p * 37 + 5);
            tick(BUSY + 40);
        end
        // One stream over the whole array and one byte past the top
        do_read(0, MEM + 1, "R9 sequential read with wrap to zero");

        // Current address read continues at 1
        bus_start();
        send_byte({ID, 1'b1}, a); chk("R12 current read command ack", a, 1);
        recv_byte(1'b1, v); chk("R12 current address byte 1", int'(v), int'(model[1]));
        recv_byte(1'b0, v); chk("R12 current address byte 2", int'(v), int'(model[2]));
        bus_stop();

        // Partial-page write that wraps inside the page, then busy refusal
        do_write(8'h1E, 10, 8'hA0);
        bus_start();
        send_byte({ID, 1'b0}, a); chk("R8 command refused while busy", a, 0);
        bus_stop();
        tick(BUSY + 40);
        do_read(8'h18, 9, "R7 in-page wrap and untouched next page");

        // Address-only header: no commit, no busy, pointer loaded
        bus_start();
        send_byte({ID, 1'b0}, a); chk("R4 header ack", a, 1);
        send_byte(8'h40, a);      chk("R5 address ack", a, 1);
        bus_stop();
        bus_start();
        send_byte({ID, 1'b1}, a); chk("R6 no busy after address-only write", a, 1);
        recv_byte(1'b0, v);       chk("R12 read at loaded address", int'(v), int'(model[8'h40]));
        bus_stop();

        // Abort mid-byte with a repeated start
        bus_start();
        send_byte({ID, 1'b0}, a); chk("R4 write command ack", a, 1);
        send_byte(8'h50, a);      chk("R5 address ack", a, 1);
        send_byte(8'h11, a);      chk("R6 data ack", a, 1);
        send_byte(8'h22, a);      chk("R6 data ack", a, 1);
        for (int i = 0; i < 4; i++) wbit(1'b1);
        bus_start();
        send_byte({ID, 1'b0}, a); chk("R11 no busy after aborted write", a, 1);
        bus_stop();
        do_read(8'h50, 3, "R11 aborted write left array unchanged");

        // Wrong identifier
        bus_start();
        send_byte({7'h51, 1'b0}, a); chk("R4 wrong identifier refused", a, 0);
        for (int i = 0; i < 8; i++) wbit(1'b0);
        rbit(b); chk("R4 bus ignored after refusal", int'(b), 1);
        bus_stop();

        // Read across the top of the array
        do_read(8'hFF, 2, "R9 read wrap from top");

        // Missing host acknowledge ends the read
        bus_start();
        send_byte({ID, 1'b0}, a); chk("R4 header ack", a, 1);
        send_byte(8'h30, a);      chk("R5 address ack", a, 1);
        bus_start();
        send_byte({ID, 1'b1}, a); chk("R2 repeated start command ack", a, 1);
        recv_byte(1'b0, v);       chk("R3 data bits MSB first", int'(v), int'(model[8'h30]));
        for (int i = 0; i < 9; i++) begin
            rbit(b);
            chk("R10 SDA released after host nack", int'(b), 1);
        end
        bus_stop();
        chk("R10 sda_oe idle", int'(sda_oe), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog (R1-R12 sequence): actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule